// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits at the front of a receive path and decides, once per frame, whether the frame is kept or discarded. Frame bytes arrive one per cycle on a byte stream. A start marker flags the first byte and an end marker flags the last. The first six bytes are taken as the destination address.

Three checks decide a frame:
- Two programmable station addresses, each with its own enable, must match exactly.
- An all-ones destination is kept when broadcast reception is enabled.
- A 64-entry hash table is looked up. Its index is found by XOR-folding the 48 destination bits into six bits.

Frames that are too short are always dropped.

Software programs the filter through a small word-wide register port. Each frame works with a copy of the configuration taken when its first byte arrives. A write made while a frame is in flight therefore takes effect from the next frame on.

Top module: `rx_addr_filter`

## Requirements
- R1: Registers are selected by `cfg_wr_sel`/`cfg_rd_sel`:
  - 0: station 0 low word. Address bytes 0..3, with byte 0 in bits 7:0.
  - 1: station 0 high word. Bytes 4..5 in bits 15:0.
  - 2 and 3: the same layout for station 1.
  - 4: hash table bits 31:0.
  - 5: hash table bits 63:32.
  - 6: receive control, bits 3:0.
  
  Unused bits and select 7 read as zero, and reset clears every register. A write is visible on `cfg_rd_data` from the next cycle.
- R2: When control bit 0 is set, a destination equal to station address 0 makes the frame accepted.
- R3: When control bit 1 is set, a destination equal to station address 1 makes the frame accepted.
- R4: When control bit 3 is set, the destination FF:FF:FF:FF:FF:FF is accepted. When bit 3 is clear, broadcast gives no hit.
- R5: Bit k of the destination is bit (k mod 8) of byte k/8, and byte 0 is the first byte on the stream. The hash index is the XOR of bit k into index bit (k mod 6), taken over all 48 bits. The frame hits when hash-table bit `index` (registers 5:4 taken as one 64-bit vector) is set.
- R6: The hash lookup applies only to group destinations, where bit 0 of byte 0 is 1. With control bit 2 set, it also applies to individual destinations.
- R7: A frame of fewer than 12 bytes is dropped whatever its address.
- R8: Each frame gives exactly one `dec_valid` pulse, in the cycle after its end-marked byte. `dec_accept` in that cycle holds the verdict. Bytes arriving outside a frame produce no pulse.
- R9: Each frame uses the configuration as it stood before the edge that takes its start byte. Register writes at that edge or later do not affect the frame.
- R10: A start marker arriving inside a frame abandons that frame without a verdict and begins a new one at that byte.
- R11: A frame with no station, broadcast or hash hit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select for writes |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 3 | Register select for reads |
| cfg_rd_data | output | 32 | Combinational read data |
| rx_valid | input | 1 | A byte is present on `rx_byte` |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_byte | input | 8 | Frame byte |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 keep, 0 drop |

## Verification
A frame's verdict is due exactly one cycle after the edge that takes its end-marked byte. Register reads are combinational and reflect a write from the cycle after it. The bench runs a behavioural model at each rising edge, which schedules the expected strobe for the next cycle. The model is compared with the outputs at every falling edge, so a verdict that arrives a cycle early or late, or a stray strobe, is caught. Read-back is checked one time unit after the read select is applied, within the same low clock phase.

// File: rtl/filt_pkg.sv
package filt_pkg;

    localparam int NUM_STA    = 2;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int HASH_W     = 6;
    localparam int HASH_SIZE  = 1 << HASH_W;
    localparam int CTL_W      = 4;

    localparam int CTL_STA0  = 0;
    localparam int CTL_STA1  = 1;
    localparam int CTL_HALL  = 2;
    localparam int CTL_BCAST = 3;

    typedef enum logic [2:0] {
        SEL_STA0_LO = 3'd0,
        SEL_STA0_HI = 3'd1,
        SEL_STA1_LO = 3'd2,
        SEL_STA1_HI = 3'd3,
        SEL_HASH_LO = 3'd4,
        SEL_HASH_HI = 3'd5,
        SEL_RXCTL   = 3'd6,
        SEL_NONE    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_STA-1:0][ADDR_W-1:0] sta;
        logic [HASH_SIZE-1:0]           hash;
        logic [CTL_W-1:0]               ctl;
    } filt_cfg_t;

    // Fold one address byte into the hash index. pos is the byte position.
    function automatic logic [HASH_W-1:0] fold_byte(input logic [7:0] b,
                                                    input logic [2:0] pos);
        logic [HASH_W-1:0] r;
        int                off;
        r   = '0;
        off = (int'(pos) * 8) % HASH_W;
        for (int j = 0; j < 8; j++) begin
            r[(j + off) % HASH_W] = r[(j + off) % HASH_W] ^ b[j];
        end
        return r;
    endfunction

endpackage

// File: rtl/filt_regs.sv
module filt_regs
    import filt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [31:0] rd_data,
    output filt_cfg_t   cfg
);

    localparam int HI_W = ADDR_W - 32;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < NUM_STA; s++) begin
                if (wr_sel == 3'(2 * s))
                    cfg.sta[s][31:0] <= wr_data;
                if (wr_sel == 3'(2 * s + 1))
                    cfg.sta[s][ADDR_W-1:32] <= wr_data[HI_W-1:0];
            end
            case (wr_sel)
                SEL_HASH_LO: cfg.hash[31:0]           <= wr_data;
                SEL_HASH_HI: cfg.hash[HASH_SIZE-1:32] <= wr_data;
                SEL_RXCTL:   cfg.ctl                  <= wr_data[CTL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_STA0_LO: rd_data = cfg.sta[0][31:0];
            SEL_STA0_HI: rd_data[HI_W-1:0] = cfg.sta[0][ADDR_W-1:32];
            SEL_STA1_LO: rd_data = cfg.sta[1][31:0];
            SEL_STA1_HI: rd_data[HI_W-1:0] = cfg.sta[1][ADDR_W-1:32];
            SEL_HASH_LO: rd_data = cfg.hash[31:0];
            SEL_HASH_HI: rd_data = cfg.hash[HASH_SIZE-1:32];
            SEL_RXCTL:   rd_data[CTL_W-1:0] = cfg.ctl;
            default:     rd_data = '0;
        endcase
    end

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_RXCTL) |=> (cfg.ctl == $past(wr_data[CTL_W-1:0]))); // R1

    AST_HASH_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_HASH_LO) |=> (cfg.hash[31:0] == $past(wr_data))); // R1

endmodule

// File: rtl/filt_match.sv
module filt_match
    import filt_pkg::*;
#(
    parameter int MIN_LEN = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic       rx_eof,
    input  logic [7:0] rx_byte,
    input  filt_cfg_t  live_cfg,
    output logic       dec_valid,
    output logic       dec_accept
);

    localparam int CNT_W = $clog2(MIN_LEN + 1);
    localparam int LAST  = ADDR_BYTES - 1;

    filt_cfg_t          snap;
    filt_cfg_t          eff;
    logic               in_frame;
    logic [CNT_W-1:0]   byte_idx;
    logic [CNT_W-1:0]   idx_cur;
    logic [2:0]         pos;
    logic               take;
    logic               first;
    logic               in_addr;
    logic [NUM_STA-1:0] sta_eq;
    logic [NUM_STA-1:0] sta_eq_nx;
    logic [NUM_STA-1:0] sta_hit;
    logic               bc_eq;
    logic               bc_eq_nx;
    logic [HASH_W-1:0]  hash_acc;
    logic [HASH_W-1:0]  hash_nx;
    logic               grp_bit;
    logic               grp_nx;
    logic               hit_nx;
    logic               addr_hit;
    logic               len_ok;

    assign take    = rx_valid && (rx_sof || in_frame);
    assign first   = rx_sof;
    assign idx_cur = first ? '0 : byte_idx;
    assign in_addr = (idx_cur < CNT_W'(ADDR_BYTES));
    assign pos     = in_addr ? idx_cur[2:0] : 3'd0;
    assign eff     = (rx_valid && rx_sof) ? live_cfg : snap;
    assign len_ok  = (idx_cur >= CNT_W'(MIN_LEN - 1));

    genvar s;
    generate
        for (s = 0; s < NUM_STA; s++) begin : g_sta
            logic [ADDR_W-1:0] shifted;
            assign shifted      = eff.sta[s] >> (8 * int'(pos));
            assign sta_eq_nx[s] = (first ? 1'b1 : sta_eq[s]) && (rx_byte == shifted[7:0]);
            assign sta_hit[s]   = sta_eq_nx[s] && eff.ctl[CTL_STA0 + s];
        end
    endgenerate

    assign bc_eq_nx = (first ? 1'b1 : bc_eq) && (rx_byte == 8'hFF);
    assign hash_nx  = (first ? '0 : hash_acc) ^ fold_byte(rx_byte, pos);
    assign grp_nx   = first ? rx_byte[0] : grp_bit;
    assign hit_nx   = (|sta_hit)
                    || (bc_eq_nx && eff.ctl[CTL_BCAST])
                    || ((grp_nx || eff.ctl[CTL_HALL]) && eff.hash[hash_nx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap       <= '0;
            in_frame   <= 1'b0;
            byte_idx   <= '0;
            sta_eq     <= '0;
            bc_eq      <= 1'b0;
            hash_acc   <= '0;
            grp_bit    <= 1'b0;
            addr_hit   <= 1'b0;
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            if (rx_valid && rx_sof)
                snap <= live_cfg;
            if (take) begin
                byte_idx <= (idx_cur >= CNT_W'(MIN_LEN)) ? CNT_W'(MIN_LEN) : idx_cur + 1'b1;
                in_frame <= !rx_eof;
                if (in_addr) begin
                    sta_eq   <= sta_eq_nx;
                    bc_eq    <= bc_eq_nx;
                    hash_acc <= hash_nx;
                    grp_bit  <= grp_nx;
                end
                if (first)
                    addr_hit <= 1'b0;
                if (idx_cur == CNT_W'(LAST))
                    addr_hit <= hit_nx;
                if (rx_eof) begin
                    dec_valid  <= 1'b1;
                    dec_accept <= addr_hit && len_ok;
                end
            end
        end
    end

    AST_VERDICT_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(rx_valid && rx_eof)); // R8

    AST_NO_VERDICT_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(!in_frame) && $past(!(rx_valid && rx_sof))) |-> !dec_valid); // R8

    AST_SHORT_DROP: assert property (@(posedge clk) disable iff (rst)
        dec_accept |-> ($past(idx_cur) >= CNT_W'(MIN_LEN - 1))); // R7

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_frame && !(rx_valid && rx_sof)) |=> $stable(snap)); // R9

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import filt_pkg::*;
#(
    parameter int MIN_LEN = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_en,
    input  logic [2:0]  cfg_wr_sel,
    input  logic [31:0] cfg_wr_data,
    input  logic [2:0]  cfg_rd_sel,
    output logic [31:0] cfg_rd_data,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_byte,
    output logic        dec_valid,
    output logic        dec_accept
);

    filt_cfg_t cfg;

    filt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .rd_sel  (cfg_rd_sel),
        .rd_data (cfg_rd_data),
        .cfg     (cfg)
    );

    filt_match #(.MIN_LEN(MIN_LEN)) u_match (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_byte    (rx_byte),
        .live_cfg   (cfg),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );

    AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        dec_accept |-> dec_valid); // R8

endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [2:0]  cfg_rd_sel = '0;
    logic [31:0] cfg_rd_data;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid;
    logic        dec_accept;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";

    always #2 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (.*);

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_live [8];
    logic [31:0] m_snap [8];
    byte         m_bytes [$];
    bit          m_in = 0;
    logic        exp_v = 0;
    logic        exp_a = 0;

    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int k = 0; k < 48; k++) h[k % 6] ^= a[k];
        return h;
    endfunction

    function automatic logic verdict(input logic [31:0] r [8], input byte q [$]);
        logic [47:0] da, s0, s1;
        logic [63:0] tbl;
        logic [3:0]  c;
        if (q.size() < 12) return 1'b0;
        for (int i = 0; i < 6; i++) da[8*i +: 8] = q[i];
        s0  = {r[1][15:0], r[0]};
        s1  = {r[3][15:0], r[2]};
        tbl = {r[5], r[4]};
        c   = r[6][3:0];
        return (c[0] && da == s0) || (c[1] && da == s1) || (c[3] && da == 48'hFFFF_FFFF_FFFF)
            || ((da[0] || c[2]) && tbl[hash_of(da)]);
    endfunction

    function automatic logic [31:0] rd_mask(input int sel);
        case (sel)
            1, 3:    return 32'h0000_FFFF;
            6:       return 32'h0000_000F;
            7:       return 32'h0;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_live[i] = '0;
            m_in = 0;
            m_bytes.delete();
            exp_v <= 1'b0;
            exp_a <= 1'b0;
        end else begin
            exp_v <= 1'b0;
            exp_a <= 1'b0;
            if (rx_valid) begin
                if (rx_sof) begin
                    for (int i = 0; i < 8; i++) m_snap[i] = m_live[i];
                    m_bytes.delete();
                    m_in = 1;
                end
                if (m_in) begin
                    m_bytes.push_back(rx_byte);
                    if (rx_eof) begin
                        exp_v <= 1'b1;
                        exp_a <= verdict(m_snap, m_bytes);
                        m_in = 0;
                    end
                end
            end
            if (cfg_wr_en && cfg_wr_sel != 3'd7)
                m_live[cfg_wr_sel] = cfg_wr_data & rd_mask(int'(cfg_wr_sel));
        end
    end

    always @(negedge clk) begin
        if (!rst && (exp_v || dec_valid)) begin
            n_checks++;
            if (dec_valid !== exp_v || (exp_v && dec_accept !== exp_a)) begin
                n_fail++;
                $display("FAIL %s: valid/accept = %0b/%0b expected %0b/%0b",
                         tag, dec_valid, dec_accept, exp_v, exp_a);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 3'(sel); cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic chk_rd(input int sel);
        @(negedge clk);
        cfg_rd_sel = 3'(sel);
        #1;
        n_checks++;
        if (cfg_rd_data !== m_live[sel & 7] && !(sel == 7 && cfg_rd_data === 32'h0)) begin
            n_fail++;
            $display("FAIL R1: read sel %0d = %h expected %h", sel, cfg_rd_data, m_live[sel & 7]);
        end
    endtask

    // wr_at >= 0: issue a register write in the cycle of that byte index
    task automatic frame(input logic [47:0] da, input int len, input int wr_at,
                         input int wsel, input logic [31:0] wdat, input bit gaps);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 2)) begin
                rx_valid = 1'b0;
                @(negedge clk);
            end
            rx_valid  = 1'b1;
            rx_sof    = (i == 0);
            rx_eof    = (i == len - 1);
            rx_byte   = (i < 6) ? da[8*i +: 8] : 8'($urandom);
            cfg_wr_en = (i == wr_at);
            cfg_wr_sel = 3'(wsel);
            cfg_wr_data = wdat;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; cfg_wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_sta(input int s, input logic [47:0] a);
        wr(2 * s, a[31:0]);
        wr(2 * s + 1, {16'h0, a[47:32]});
    endtask

    // ---------------- scenarios ----------------
    task automatic run_all();
        logic [47:0] a0, a1, g_lo, g_hi, ind;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        tag = "R1";
        for (int i = 0; i < 8; i++) chk_rd(i);
        wr(0, 32'hDEAD_BEEF); wr(1, 32'hFFFF_1234); wr(6, 32'hFFFF_FFF5); wr(5, 32'h8000_0001);
        for (int i = 0; i < 8; i++) chk_rd(i);
        wr(6, 32'h0); wr(5, 32'h0);

        a0 = 48'h5544_3322_1100;   // byte 0 = 0x00, individual
        a1 = 48'h0A0B_0C0D_0E02;
        set_sta(0, a0); set_sta(1, a1);
        tag = "R2"; wr(6, 32'h1); frame(a0, 20, -1, 0, 0, 0);
        tag = "R11"; frame(a1, 20, -1, 0, 0, 0);
        wr(6, 32'h0); frame(a0, 20, -1, 0, 0, 0);
        tag = "R3"; wr(6, 32'h2); frame(a1, 16, -1, 0, 0, 0);
        frame(a0, 16, -1, 0, 0, 0);
        tag = "R4"; wr(6, 32'h8); frame(48'hFFFF_FFFF_FFFF, 14, -1, 0, 0, 0);
        wr(6, 32'h0); frame(48'hFFFF_FFFF_FFFF, 14, -1, 0, 0, 0);

        tag = "R5";
        g_lo = 48'h1234_5678_9A01;
        while (hash_of(g_lo) > 31) g_lo = g_lo + 48'h100;
        g_hi = 48'h1234_5678_9A01;
        while (hash_of(g_hi) < 32) g_hi = g_hi + 48'h100;
        wr(4, 32'h1 << hash_of(g_lo));
        frame(g_lo, 13, -1, 0, 0, 0);
        frame(g_hi, 13, -1, 0, 0, 0);
        wr(4, 32'h0); wr(5, 32'h1 << (hash_of(g_hi) - 32));
        frame(g_hi, 13, -1, 0, 0, 1);
        frame(g_lo, 13, -1, 0, 0, 0);

        tag = "R6";
        ind = 48'h0102_0304_0506;
        wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
        frame(ind, 12, -1, 0, 0, 0);
        wr(6, 32'h4); frame(ind, 12, -1, 0, 0, 0);
        wr(4, 32'h0); wr(5, 32'h0);

        tag = "R7"; wr(6, 32'h1);
        frame(a0, 11, -1, 0, 0, 0);
        frame(a0, 12, -1, 0, 0, 0);
        frame(a0, 1, -1, 0, 0, 0);

        tag = "R8";
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_eof = (i == 4); rx_byte = 8'(i);
        end
        @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
        repeat (2) @(negedge clk);

        tag = "R9";
        frame(a0, 15, 3, 6, 32'h0, 0);
        frame(a0, 15, -1, 0, 0, 0);
        frame(a0, 15, 0, 6, 32'h1, 0);
        frame(a0, 15, -1, 0, 0, 0);
        frame(a0, 15, 8, 0, 32'h0, 0);
        frame(a0, 15, -1, 0, 0, 0);
        set_sta(0, a0);

        tag = "R10";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = 8'hFF;
        end
        rx_valid = 1'b0; rx_sof = 1'b0;
        frame(a0, 12, -1, 0, 0, 0);

        tag = "R11";
        for (int n = 0; n < 300; n++) begin
            logic [47:0] da;
            case ($urandom % 4)
                0: da = a0;
                1: da = a1;
                2: da = 48'hFFFF_FFFF_FFFF;
                default: da = {$urandom, 16'($urandom)};
            endcase
            if (n % 10 == 0) begin
                wr(6, $urandom); wr(4, $urandom); wr(5, $urandom);
            end
            frame(da, 8 + ($urandom % 10), (n % 7 == 0) ? 2 : -1, 6, $urandom, n[0]);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule